// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for a small serial EEPROM of 256 words by 16 bits. A host drives a select line, a serial clock and a serial data input, and the model answers on one serial data output. The three host pins are brought into the fast system clock domain through synchronizers. The model detects rising serial-clock edges from the synchronized copies and decodes an instruction frame. The frame is a start bit, a two-bit opcode, an eight-bit address and, for the data-carrying commands, sixteen data bits. The storage is an internal register array that reset loads with a computed pattern.

Reads are always allowed. All array changes are gated by an enable latch, which the host sets and clears with dedicated commands. A successful change starts a self-timed programming period. Its length is a parameter counted in system clock cycles, and the model refuses new instructions until it ends. The host can poll this period by dropping the select line and raising it again. The output then shows 0 while programming runs and 1 once it has finished.

Top module: `mwEeprom`

## Requirements
- R1: After reset the output is 0, programming is disabled, and word `a` holds `INIT_BASE + a` truncated to 16 bits.
- R2: A frame starts with the first 1 sampled on a rising serial-clock edge while select is high. Zeros sampled before it are ignored. The start bit is followed by a 2-bit opcode, then an 8-bit address, each sent MSB first.
- R3: Opcode 10 reads. After the last address bit the output is a 0 placeholder bit. Each later rising serial-clock edge presents the next data bit, MSB first. The output changes only in response to such an edge. Reads work whether programming is enabled or not.
- R4: Opcode 00 with address bits [7:6] = 11 sets the enable latch, and with [7:6] = 00 clears it. The latch keeps its value until the other command or a reset.
- R5: Opcode 01 followed by 16 data bits (MSB first) stores the data at the address when programming is enabled.
- R6: Opcode 11 sets every bit of the addressed word to 1 when enabled.
- R7: Opcode 00 with [7:6] = 10 sets every word to FFFF. Opcode 00 with [7:6] = 01, followed by 16 data bits, stores that pattern in every word. Both act only when enabled.
- R8: With programming disabled, commands 01, 11 and the two whole-array commands leave the array unchanged and start no programming period.
- R9: An accepted array change starts a busy period of PROG_CYCLES system clocks. It begins after the last data bit for the data-carrying commands and after the last address bit for the others. If select goes low and then high while the period runs, the output shows 0 while busy and 1 once done. If select rises only after the period has ended, the output stays 0.
- R10: Bits received while the busy period runs start no instruction and change nothing.
- R11: Select going low abandons a partly received frame without effect.
- R12: The output is 0 whenever select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every host pin |
| rstN | input | 1 | Active-low asynchronous reset |
| selIn | input | 1 | Chip select from the host, active high |
| serClk | input | 1 | Serial clock from the host |
| serIn | input | 1 | Serial data from the host |
| serOut | output | 1 | Serial data and status back to the host |

## Verification
A corrupted frame counter or opcode register shows up as a wrong bit during the next read, within one serial-clock period of the place where the frame went wrong. A stuck enable latch or a busy counter of the wrong length shows up on the first status poll. A busy period that starts when it should not is just as visible, because the output reads 1 or 0 on a select toggle where the opposite is due. A bad write or erase decode stays hidden until the affected word is read back, so the sequence reads every touched word, and one untouched neighbour, after each change.

// File: rtl/mwPkg.sv
package mwPkg;
  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_DISABLE = 2'b00;
  localparam logic [1:0] SUB_WRALL   = 2'b01;
  localparam logic [1:0] SUB_ERALL   = 2'b10;
  localparam logic [1:0] SUB_ENABLE  = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADDR, S_EXEC, S_DATA, S_COMMIT, S_READ, S_DONE
  } ctrlState_t;

  typedef struct packed {
    logic shiftAddr;
    logic shiftData;
    logic loadRead;
    logic shiftOut;
    logic wrWord;
    logic eraseWord;
    logic eraseAll;
    logic wrAll;
    logic setEn;
    logic clrEn;
    logic rdActive;
    logic statusMode;
  } mwStrobe_t;
endpackage

// File: rtl/mwSync.sv
module mwSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic selIn,
  input  logic serClk,
  input  logic serIn,
  output logic selS,
  output logic dataS,
  output logic clkRise,
  output logic selRise
);
  logic [2:0] pipe [STAGES];
  logic clkPrev, selPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      clkPrev <= 1'b0;
      selPrev <= 1'b0;
    end else begin
      pipe[0] <= {selIn, serClk, serIn};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      clkPrev <= pipe[STAGES-1][1];
      selPrev <= pipe[STAGES-1][2];
    end
  end

  assign selS    = pipe[STAGES-1][2];
  assign dataS   = pipe[STAGES-1][0];
  assign clkRise = pipe[STAGES-1][1] & ~clkPrev;
  assign selRise = pipe[STAGES-1][2] & ~selPrev;
endmodule

// File: rtl/mwCtrl.sv
module mwCtrl
  import mwPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selS,
  input  logic      selRise,
  input  logic      clkRise,
  input  logic      dataS,
  input  logic      busy,
  output mwStrobe_t stb
);
  localparam int MAXW  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXW);

  ctrlState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0]       opc, sub;
  logic             statusMode;
  logic             lastAddr, lastData, needsData;

  assign lastAddr  = bitCnt == CNT_W'(ADDR_W - 1);
  assign lastData  = bitCnt == CNT_W'(DATA_W - 1);
  assign needsData = (opc == OP_WRITE) || ((opc == OP_SPECIAL) && (sub == SUB_WRALL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      bitCnt     <= '0;
      opc        <= '0;
      sub        <= '0;
      statusMode <= 1'b0;
    end else if (!selS) begin
      state      <= S_IDLE;
      bitCnt     <= '0;
      statusMode <= 1'b0;
    end else begin
      if (selRise) statusMode <= busy;
      case (state)
        S_IDLE: if (clkRise && dataS && !busy) begin
          state      <= S_OPC;
          bitCnt     <= '0;
          statusMode <= 1'b0;
        end
        S_OPC: if (clkRise) begin
          opc <= {opc[0], dataS};
          if (bitCnt == CNT_W'(1)) begin
            bitCnt <= '0;
            state  <= S_ADDR;
          end else bitCnt <= bitCnt + CNT_W'(1);
        end
        S_ADDR: if (clkRise) begin
          if (bitCnt < CNT_W'(2)) sub <= {sub[0], dataS};
          if (lastAddr) begin
            bitCnt <= '0;
            state  <= needsData ? S_DATA : S_EXEC;
          end else bitCnt <= bitCnt + CNT_W'(1);
        end
        S_DATA: if (clkRise) begin
          if (lastData) begin
            bitCnt <= '0;
            state  <= S_COMMIT;
          end else bitCnt <= bitCnt + CNT_W'(1);
        end
        S_EXEC:   state <= (opc == OP_READ) ? S_READ : S_DONE;
        S_COMMIT: state <= S_DONE;
        default: ;
      endcase
    end
  end

  always_comb begin
    stb            = '0;
    stb.shiftAddr  = (state == S_ADDR) && clkRise;
    stb.shiftData  = (state == S_DATA) && clkRise;
    stb.loadRead   = (state == S_EXEC) && (opc == OP_READ);
    stb.eraseWord  = (state == S_EXEC) && (opc == OP_ERASE);
    stb.eraseAll   = (state == S_EXEC) && (opc == OP_SPECIAL) && (sub == SUB_ERALL);
    stb.setEn      = (state == S_EXEC) && (opc == OP_SPECIAL) && (sub == SUB_ENABLE);
    stb.clrEn      = (state == S_EXEC) && (opc == OP_SPECIAL) && (sub == SUB_DISABLE);
    stb.wrWord     = (state == S_COMMIT) && (opc == OP_WRITE);
    stb.wrAll      = (state == S_COMMIT) && (opc == OP_SPECIAL);
    stb.shiftOut   = (state == S_READ) && clkRise;
    stb.rdActive   = (state == S_READ);
    stb.statusMode = statusMode;
  end
endmodule

// File: rtl/mwDatapath.sv
module mwDatapath
  import mwPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 5000,
  parameter int INIT_BASE   = 'hA500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      dataS,
  input  mwStrobe_t stb,
  output logic      busy,
  output logic      progEn,
  output logic      serOut
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  logic [ADDR_W-1:0]             addrReg;
  logic [DATA_W-1:0]             dataReg;
  logic [DATA_W:0]               outReg;
  logic [TW-1:0]                 busyCnt;
  logic [DEPTH-1:0][DATA_W-1:0]  memView;
  logic                          progGo;

  assign progGo = progEn && (stb.wrWord || stb.eraseWord || stb.eraseAll || stb.wrAll);
  assign busy   = busyCnt != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      outReg  <= '0;
      busyCnt <= '0;
      progEn  <= 1'b0;
    end else begin
      if (stb.shiftAddr) addrReg <= {addrReg[ADDR_W-2:0], dataS};
      if (stb.shiftData) dataReg <= {dataReg[DATA_W-2:0], dataS};
      if (stb.loadRead)      outReg <= {1'b0, memView[addrReg]};
      else if (stb.shiftOut) outReg <= {outReg[DATA_W-1:0], 1'b0};
      if (stb.setEn)      progEn <= 1'b1;
      else if (stb.clrEn) progEn <= 1'b0;
      if (progGo)    busyCnt <= TW'(PROG_CYCLES);
      else if (busy) busyCnt <= busyCnt - TW'(1);
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] word;
    logic              hit;
    assign hit = addrReg == ADDR_W'(w);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) word <= DATA_W'(INIT_BASE + w);
      else if (progEn) begin
        if (stb.eraseAll || (stb.eraseWord && hit)) word <= '1;
        else if (stb.wrAll || (stb.wrWord && hit))  word <= dataReg;
      end
    end
    assign memView[w] = word;
  end

  assign serOut = stb.statusMode ? !busy :
                  stb.rdActive   ? outReg[DATA_W] : 1'b0;
endmodule

// File: rtl/mwEeprom.sv
module mwEeprom
  import mwPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 5000,
  parameter int INIT_BASE   = 'hA500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic selIn,
  input  logic serClk,
  input  logic serIn,
  output logic serOut
);
  logic      selS, dataS, clkRise, selRise;
  logic      busy, progEn;
  mwStrobe_t stb;

  mwSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .selIn(selIn), .serClk(serClk), .serIn(serIn),
    .selS(selS), .dataS(dataS), .clkRise(clkRise), .selRise(selRise)
  );

  mwCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selS(selS), .selRise(selRise),
    .clkRise(clkRise), .dataS(dataS), .busy(busy), .stb(stb)
  );

  mwDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES), .INIT_BASE(INIT_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dataS(dataS), .stb(stb),
    .busy(busy), .progEn(progEn), .serOut(serOut)
  );
endmodule

// File: rtl/mwEepromChk.sv
module mwEepromChk
  import mwPkg::*;
#(
  parameter int PROG_CYCLES = 5000
) (
  input logic      clk,
  input logic      rstN,
  input logic      selS,
  input logic      clkRise,
  input logic      busy,
  input logic      progEn,
  input mwStrobe_t stb,
  input logic      serOut
);
  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  p_quiet_deselected_r12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!selS) && !selS) |-> !serOut);

  p_no_prog_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(progEn));

  p_busy_bounded_r9: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= PROG_CYCLES);

  p_busy_full_length_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == PROG_CYCLES));

  p_latch_by_command_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(progEn) |-> $past(stb.setEn || stb.clrEn));

  p_read_moves_on_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.rdActive) && stb.rdActive && !$stable(serOut)) |-> $past(clkRise));

  p_nothing_starts_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(stb.wrWord || stb.eraseWord || stb.eraseAll || stb.wrAll || stb.setEn || stb.clrEn));
endmodule

bind mwEeprom mwEepromChk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .selS(selS), .clkRise(clkRise), .busy(busy),
  .progEn(progEn), .stb(stb), .serOut(serOut)
);

// File: tb/sim_mwEeprom.sv
module sim_mwEeprom;
  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 1000;
  localparam int BASE       = 'hA500;
  localparam int HALF       = 8;
  localparam int SETTLE     = 6;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rstN = 1'b0, selIn = 1'b0, serClk = 1'b0, serIn = 1'b0;
  logic serOut;

  mwEeprom #(.PROG_CYCLES(PROG), .INIT_BASE(BASE)) u0 (
    .clk(clk), .rstN(rstN), .selIn(selIn), .serClk(serClk), .serIn(serIn), .serOut(serOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, vectors = 0, miscompares = 0, settle = 0, busyUntil = 0, riseCyc = 0;
  bit checking = 0, statusExp = 0, en = 0;
  logic expDo = 1'b0;
  string curReq = "R1";
  logic [15:0] mem [256];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog expired in %s: actual running expected finished", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // Per-clock comparison against the behavioural expectation
  always @(negedge clk) begin
    logic e;
    if (checking) begin
      if (settle > 0) settle = settle - 1;
      else if (statusExp && cyc > busyUntil - 6 && cyc < busyUntil + 6) ;
      else begin
        e = statusExp ? (cyc >= busyUntil) : expDo;
        vectors = vectors + 1;
        if (serOut !== e) begin
          miscompares = miscompares + 1;
          $display("FAIL %s: serOut=%0b expected %0b at cycle %0d", curReq, serOut, e, cyc);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkWord(input string req, input logic [15:0] got, input logic [15:0] exp);
    vectors = vectors + 1;
    if (got !== exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(input bit b, input int nextExp, input bit clrStatus, output logic seen);
    serIn = b;
    tick(HALF);
    serClk = 1'b1;
    riseCyc = cyc;
    settle = SETTLE;
    if (nextExp >= 0) expDo = nextExp[0];
    if (clrStatus) statusExp = 0;
    tick(HALF);
    seen = serOut;
    serClk = 1'b0;
  endtask

  task automatic selHigh();
    selIn = 1'b1;
    settle = SETTLE;
    statusExp = (cyc < busyUntil);
    tick(HALF);
  endtask

  task automatic selLow();
    selIn = 1'b0;
    settle = SETTLE;
    statusExp = 0;
    expDo = 1'b0;
    tick(HALF);
  endtask

  task automatic header(input bit [1:0] op, input bit [7:0] a, input bit clr);
    logic s;
    pulse(1'b1, -1, clr, s);
    for (int i = 1; i >= 0; i--) pulse(op[i], -1, 0, s);
    for (int i = 7; i >= 0; i--) pulse(a[i], -1, 0, s);
  endtask

  task automatic rd(input string req, input bit [7:0] a, input int zeros);
    logic s;
    logic [15:0] got;
    curReq = req;
    selHigh();
    for (int i = 0; i < zeros; i++) pulse(1'b0, -1, 0, s);
    header(2'b10, a, 1);
    checkWord({req, " placeholder"}, {15'd0, serOut}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      pulse(1'b0, int'(mem[a][i]), 0, s);
      got[i] = s;
    end
    checkWord(req, got, mem[a]);
    selLow();
  endtask

  // kind: 0 word write, 1 word erase, 2 erase all, 3 write all, 4 enable, 5 disable
  task automatic cmd(input string req, input bit [1:0] op, input bit [7:0] a,
                     input bit hasData, input bit [15:0] d, input int kind);
    logic s;
    curReq = req;
    selHigh();
    header(op, a, 1);
    if (hasData) for (int i = 15; i >= 0; i--) pulse(d[i], -1, 0, s);
    if (kind == 4) en = 1;
    else if (kind == 5) en = 0;
    else if (en) begin
      busyUntil = riseCyc + 4 + PROG;
      case (kind)
        0: mem[a] = d;
        1: mem[a] = 16'hFFFF;
        2: for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
        default: for (int i = 0; i < 256; i++) mem[i] = d;
      endcase
    end
    selLow();
  endtask

  task automatic poll(input string req);
    curReq = req;
    selHigh();
    checkWord({req, " busy"}, {15'd0, serOut}, 16'd0);
    while (cyc < busyUntil + 10) tick(1);
    checkWord({req, " ready"}, {15'd0, serOut}, 16'd1);
    selLow();
  endtask

  initial begin
    logic s;
    for (int i = 0; i < 256; i++) mem[i] = 16'(BASE + i);
    tick(5);
    rstN = 1'b1;
    settle = SETTLE;
    checking = 1;
    tick(4);
    // R1: reset state
    checkWord("R1 output after reset", {15'd0, serOut}, 16'd0);
    rd("R1 initial word 00", 8'h00, 0);
    rd("R3 read word 5A", 8'h5A, 0);
    rd("R1 initial word FF", 8'hFF, 0);

    // R8: disabled write has no effect and no busy period
    cmd("R8 write while disabled", 2'b01, 8'h10, 1, 16'h1234, 0);
    curReq = "R8 no status after disabled write";
    selHigh();
    checkWord("R8 no status", {15'd0, serOut}, 16'd0);
    selLow();
    rd("R8 word 10 unchanged", 8'h10, 0);

    // R4 enable, R5 write, R9 poll
    cmd("R4 enable", 2'b00, 8'hC0, 0, 16'h0, 4);
    cmd("R5 write word 10", 2'b01, 8'h10, 1, 16'h1234, 0);
    poll("R9 poll after write");
    rd("R5 word 10 written", 8'h10, 0);
    rd("R5 neighbour 11 kept", 8'h11, 0);

    // R2: leading zeros before start bit
    rd("R2 leading zeros ignored", 8'h10, 3);

    // R6: erase one word
    cmd("R6 erase word 5A", 2'b11, 8'h5A, 0, 16'h0, 1);
    poll("R9 poll after erase");
    rd("R6 word 5A erased", 8'h5A, 0);
    rd("R6 neighbour 5B kept", 8'h5B, 0);

    // R9: select raised after period has ended shows nothing
    cmd("R5 write word 20", 2'b01, 8'h20, 1, 16'hBEEF, 0);
    while (cyc < busyUntil + 20) tick(1);
    curReq = "R9 late select";
    selHigh();
    checkWord("R9 no status after end", {15'd0, serOut}, 16'd0);
    selLow();
    rd("R5 word 20 written", 8'h20, 0);

    // R10: instruction during busy period ignored
    cmd("R5 write word 30", 2'b01, 8'h30, 1, 16'h0F0F, 0);
    curReq = "R10 bits while busy";
    selHigh();
    header(2'b11, 8'h31, 0);
    while (cyc < busyUntil + 10) tick(1);
    checkWord("R10 status still shown", {15'd0, serOut}, 16'd1);
    selLow();
    rd("R10 word 31 untouched", 8'h31, 0);
    rd("R5 word 30 written", 8'h30, 0);

    // R11: abort a partial write
    curReq = "R11 partial frame";
    selHigh();
    header(2'b01, 8'h40, 1);
    for (int i = 0; i < 8; i++) pulse(1'b0, -1, 0, s);
    selLow();
    checkWord("R12 output low when deselected", {15'd0, serOut}, 16'd0);
    rd("R11 word 40 untouched", 8'h40, 0);

    // R7: write all, then erase all
    cmd("R7 write all", 2'b00, 8'h40, 1, 16'hC3C3, 3);
    poll("R9 poll after write all");
    rd("R7 write all word 00", 8'h00, 0);
    rd("R7 write all word 7F", 8'h7F, 0);
    rd("R7 write all word FF", 8'hFF, 0);
    cmd("R7 erase all", 2'b00, 8'h80, 0, 16'h0, 2);
    poll("R9 poll after erase all");
    rd("R7 erase all word 00", 8'h00, 0);
    rd("R7 erase all word A5", 8'hA5, 0);

    // R4 disable, R8 blocked write, R3 read while disabled
    cmd("R4 disable", 2'b00, 8'h00, 0, 16'h0, 5);
    cmd("R8 write after disable", 2'b01, 8'h00, 1, 16'h0000, 0);
    curReq = "R4 latch cleared";
    selHigh();
    checkWord("R4 no status when disabled", {15'd0, serOut}, 16'd0);
    selLow();
    rd("R3 read while disabled", 8'h00, 0);

    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule